// File: doc/BRIEF.md
# Prescaled Interval Timer with Overrun Countdown

This block is an 8-bit down-counting interval timer that sits on a small register bus. The address of a timer write does three jobs. It selects a division ratio of 1, 8, 64 or 1024 input clocks per count step. It sets or clears the timer interrupt enable. The write data gives the starting count. When the count runs out, the block raises a timer flag. It then keeps counting at full clock rate from 0xFF and wraps every 256 clocks. Software can read this overrun count to find out how long ago the interval ended.

Any timer access clears the flag, whether a read or a write. There is one exception: a read that returns 0xFF while the timer is in the overrun phase leaves the flag set. A masked request is formed from the flag and the enable. That request is ORed with an interrupt from a neighbouring block to drive a single active-high interrupt line. Bit 7 of the shared flag byte carries the timer flag.

Read data is combinational and always shows the register that the address selects. Read side effects happen only at the clock edge where the read strobe is high.

Top module: `prescaled_timer`

## Requirements
- R1: After reset the division shift is 10 and the timer is counting with 256×1024 clocks left. A timer read shows 0x00 in the reset state and 0xFF one clock later. The flag and the enable are both 0, so irq equals extIrq.
- R2: A write loads the timer only when addr[4]=1 and addr[2]=1. In that case addr[1:0] = 0, 1, 2 or 3 selects shift 0, 3, 6 or 10. A write with addr[4]=0 or addr[2]=0 leaves the timer count unchanged.
- R3: A write of N with shift s starts a countdown of R = N·2^s + 1 clocks. The clock edge of the write counts as k=0. At clock k, for k ≤ N·2^s, the timer read value (addr[2]=1, addr[0]=0) is (R−k) >> s and the flag is 0.
- R4: At edge k = N·2^s + 1 the flag becomes 1. Reading the flag byte (addr[2]=1, addr[0]=1) returns the flag in bit 7 and zeros in bits 6:0. Reading it with rdEn does not clear the flag. Any other address with addr[2]=0 reads 0x00.
- R5: After expiry the read value is 0xFF. It then falls by 1 every clock, unshifted, and wraps from 0x00 back to 0xFF indefinitely.
- R6: A timer write clears the flag and returns the timer to the counting phase.
- R7: A timer read with rdEn clears the flag at that edge. The exception is a read in the overrun phase whose read value is 0xFF; that read leaves the flag set.
- R8: On a timer read with rdEn, and on a timer write, addr[3] sets the enable to 1 or clears it to 0. timerIrq = flag AND enable, and irq = timerIrq OR extIrq.
- R9: A timer write at the edge where expiry would occur takes priority. The flag stays 0 and the timer counts down from the new load.
- R10: A timer read at the expiry edge does not prevent the flag from being set. The flag becomes 1 and the read value becomes 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter and the bus are sampled on the rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 5 | Register address |
| wrEn | input | 1 | Single-cycle write strobe |
| rdEn | input | 1 | Single-cycle read strobe; enables read side effects |
| wrData | input | 8 | Write data, used as the timer load value |
| extIrq | input | 1 | Interrupt request from the neighbouring block |
| rdData | output | 8 | Combinational read data for the addressed register |
| timerFlag | output | 1 | Timer expiry flag |
| timerIrq | output | 1 | Timer flag masked by the enable |
| irq | output | 1 | Combined interrupt request, active high |

## Verification
The hardest situations to reach are the single edges where expiry coincides with a bus access. These are a write or a read landing on the last counting clock, and a read landing on the one clock where the overrun value is 0xFF. The bench reaches each of them with short loads at division 1, where the remaining count is exact every clock. It peeks at the read value without a strobe to find the target cycle, then issues the access in exactly that cycle. Prescaler sweeps over all four ratios, followed through expiry and one full wrap, check every intermediate read value against the arithmetic countdown.

// File: rtl/prescaled_timer_pkg.sv
package prescaled_timer_pkg;

  localparam int MAX_SHIFT = 10;
  localparam int SH_W      = $clog2(MAX_SHIFT + 1);

  // address bit positions
  localparam int A_LOW  = 0;
  localparam int A_REG  = 2;
  localparam int A_IEN  = 3;
  localparam int A_TSEL = 4;

  typedef struct packed {
    logic       load;
    logic [1:0] sel;
    logic       expire;
    logic       overrun;
  } tmrCtl_t;

  function automatic logic [SH_W-1:0] shiftOf(input logic [1:0] sel);
    case (sel)
      2'd0:    return SH_W'(0);
      2'd1:    return SH_W'(3);
      2'd2:    return SH_W'(6);
      default: return SH_W'(MAX_SHIFT);
    endcase
  endfunction

endpackage

// File: rtl/tmr_dpath.sv
module tmr_dpath
  import prescaled_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrCtl_t          ctl,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] timVal,
  output logic             lastTick
);

  localparam int RW = CNT_W + MAX_SHIFT + 1;

  logic [RW-1:0]   remCnt;
  logic [SH_W-1:0] shAmt;
  logic [RW-1:0]   shifted;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remCnt <= RW'(1) << (CNT_W + MAX_SHIFT);
      shAmt  <= SH_W'(MAX_SHIFT);
    end else if (ctl.load) begin
      remCnt <= (RW'(loadVal) << shiftOf(ctl.sel)) + RW'(1);
      shAmt  <= shiftOf(ctl.sel);
    end else if (ctl.expire) begin
      remCnt <= RW'({CNT_W{1'b1}});
    end else if (ctl.overrun) begin
      remCnt <= RW'(remCnt[CNT_W-1:0] - CNT_W'(1));
    end else begin
      remCnt <= remCnt - RW'(1);
    end
  end

  assign shifted  = remCnt >> shAmt;
  assign timVal   = ctl.overrun ? remCnt[CNT_W-1:0] : shifted[CNT_W-1:0];
  assign lastTick = (remCnt == RW'(1));

  // R5: overrun count wraps from zero to all ones
  p_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.overrun && !ctl.load && remCnt[CNT_W-1:0] == '0
      |=> remCnt[CNT_W-1:0] == {CNT_W{1'b1}});

  // R3: a counting timer never holds zero clocks remaining
  p_count_nonzero_r3: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.overrun |-> remCnt != '0);

endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import prescaled_timer_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [CNT_W-1:0]  timVal,
  input  logic              lastTick,
  output tmrCtl_t           ctl,
  output logic [CNT_W-1:0]  rdData,
  output logic              timerFlag,
  output logic              tmrEn
);

  typedef enum logic { ST_COUNT, ST_OVR } tmrState_e;

  tmrState_e state;
  logic      wrTim, timRdAddr, flagRdAddr, timRd;
  logic      atFF, clrFlag;

  assign wrTim      = wrEn && addr[A_TSEL] && addr[A_REG];
  assign timRdAddr  = addr[A_REG] && !addr[A_LOW];
  assign flagRdAddr = addr[A_REG] &&  addr[A_LOW];
  assign timRd      = rdEn && timRdAddr;
  assign atFF       = (state == ST_OVR) && (timVal == {CNT_W{1'b1}});
  assign clrFlag    = wrTim || (timRd && !atFF);

  always_comb begin
    ctl.load    = wrTim;
    ctl.sel     = addr[1:0];
    ctl.expire  = (state == ST_COUNT) && lastTick && !wrTim;
    ctl.overrun = (state == ST_OVR);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_COUNT;
      timerFlag <= 1'b0;
      tmrEn     <= 1'b0;
    end else begin
      if (wrTim)           state <= ST_COUNT;
      else if (ctl.expire) state <= ST_OVR;

      if (ctl.expire)      timerFlag <= 1'b1;
      else if (clrFlag)    timerFlag <= 1'b0;

      if (wrTim || timRd)  tmrEn <= addr[A_IEN];
    end
  end

  always_comb begin
    if (timRdAddr)       rdData = timVal;
    else if (flagRdAddr) rdData = {timerFlag, {(CNT_W-1){1'b0}}};
    else                 rdData = '0;
  end

  // R4: expiry raises the flag
  p_flag_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.expire |=> timerFlag && state == ST_OVR);

  // R6: a write clears the flag and restarts counting
  p_write_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    wrTim |=> !timerFlag && state == ST_COUNT);

  // R7: reading 0xFF in overrun keeps the flag
  p_read_ff_keeps_r7: assert property (@(posedge clk) disable iff (!rstN)
    timRd && atFF && timerFlag && !wrTim |=> timerFlag);

  // R7: any other timer read clears it
  p_read_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    timRd && !atFF && !wrTim && !ctl.expire |=> !timerFlag);

  // R9: a write on the expiry edge wins
  p_write_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    wrTim && lastTick && state == ST_COUNT |=> state == ST_COUNT && !timerFlag);

  // R8: the enable follows addr[3] of the access
  p_enable_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrTim || timRd) |=> tmrEn == $past(addr[A_IEN]));

endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
  import prescaled_timer_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [CNT_W-1:0]  wrData,
  input  logic              extIrq,
  output logic [CNT_W-1:0]  rdData,
  output logic              timerFlag,
  output logic              timerIrq,
  output logic              irq
);

  tmrCtl_t          ctl;
  logic [CNT_W-1:0] timVal;
  logic             lastTick;
  logic             tmrEn;

  tmr_ctrl #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .timVal(timVal), .lastTick(lastTick), .ctl(ctl), .rdData(rdData),
    .timerFlag(timerFlag), .tmrEn(tmrEn)
  );

  tmr_dpath #(.CNT_W(CNT_W)) uDpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .loadVal(wrData),
    .timVal(timVal), .lastTick(lastTick)
  );

  assign timerIrq = timerFlag && tmrEn;
  assign irq      = timerIrq || extIrq;

  // R8: an enabled, set flag always reaches the interrupt line
  p_irq_r8: assert property (@(posedge clk) disable iff (!rstN)
    timerFlag && tmrEn |-> irq && timerIrq);

endmodule

// File: tb/tb_prescaled_timer.sv
module tb_prescaled_timer;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] addr = '0;
  logic       wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       extIrq = 1'b0;
  logic [7:0] rdData;
  logic       timerFlag, timerIrq, irq;

  int nChecks = 0, nErr = 0;
  bit done = 0;

  always #4 clk = ~clk;

  prescaled_timer dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .extIrq(extIrq), .rdData(rdData),
    .timerFlag(timerFlag), .timerIrq(timerIrq), .irq(irq)
  );

  localparam logic [4:0] RD_TIM  = 5'b00100;
  localparam logic [4:0] RD_TIME = 5'b01100;
  localparam logic [4:0] RD_FLAG = 5'b00101;

  function automatic int shOf(input int sel);
    case (sel)
      0: return 0;
      1: return 3;
      2: return 6;
      default: return 10;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic peek(input logic [4:0] a, output int v);
    addr = a;
    rdEn = 1'b0;
    #1 v = int'(rdData);
  endtask

  task automatic wr(input logic [4:0] a, input int d);
    addr = a; wrData = 8'(d); wrEn = 1'b1;
    step;
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a);
    addr = a; rdEn = 1'b1;
    step;
    rdEn = 1'b0;
  endtask

  // R2 R3 R4 R5: full countdown, expiry and one wrap
  task automatic sweep(input int sel, input int n);
    int sh, d, v, exp, ef;
    sh = shOf(sel);
    d  = n << sh;
    wr({3'b101, 2'(sel)}, n);
    for (int k = 0; k <= d + 1 + 300; k++) begin
      peek(RD_TIM, v);
      if (k <= d) begin
        exp = (d + 1 - k) >> sh; ef = 0;
        check("R3 count", v, exp & 255);
      end else begin
        exp = (255 - (k - d - 1)) & 255; ef = 1;
        check("R5 overrun", v, exp);
      end
      check("R4 flag", int'(timerFlag), ef);
      step;
    end
    peek(RD_FLAG, v);
    check("R4 flag byte", v, 8'h80);
  endtask

  initial begin
    int v;
    repeat (3) step;
    rstN = 1'b1;
    // R1 reset state
    peek(RD_TIM, v);
    check("R1 reset read", v, 0);
    check("R1 reset flag", int'(timerFlag), 0);
    check("R1 reset irq", int'(irq), 0);
    extIrq = 1'b1; #1;
    check("R1 R8 ext irq", int'(irq), 1);
    extIrq = 1'b0;
    step;
    peek(RD_TIM, v);
    check("R1 one clock", v, ((1 << 18) - 1) >> 10);
    step;
    peek(RD_TIM, v);
    check("R1 two clocks", v, ((1 << 18) - 2) >> 10);

    // R2 R3 R4 R5 sweeps over every ratio
    for (int s = 0; s < 3; s++) begin
      sweep(s, 0); sweep(s, 1); sweep(s, 3); sweep(s, 255);
    end
    sweep(3, 0); sweep(3, 1); sweep(3, 2);

    // R2: non-timer writes leave the count alone
    wr(5'b10101, 100);               // shift 3, R = 801
    wr(5'b00100, 7);                 // addr[4]=0
    peek(RD_TIM, v);
    check("R2 ignore a4", v, 800 >> 3);
    wr(5'b10011, 9);                 // addr[2]=0
    peek(RD_TIM, v);
    check("R2 ignore a2", v, 799 >> 3);

    // R4: other address reads zero; flag byte shows clear flag
    peek(5'b00000, v);
    check("R4 other addr", v, 0);
    peek(RD_FLAG, v);
    check("R4 flag byte clear", v, 0);

    // R7 R8: read at 0xFF keeps flag and sets enable
    wr(5'b10100, 0);                 // R = 1, enable 0
    step;                            // expiry
    check("R5 expire flag", int'(timerFlag), 1);
    check("R8 masked", int'(irq), 0);
    peek(RD_TIM, v);
    check("R5 expire ff", v, 255);
    rd(RD_TIME);
    check("R7 ff keeps flag", int'(timerFlag), 1);
    check("R8 read enables", int'(timerIrq), 1);
    check("R8 irq", int'(irq), 1);
    peek(RD_TIM, v);
    check("R5 fe", v, 254);
    rd(RD_TIM);
    check("R7 read clears", int'(timerFlag), 0);
    check("R8 read disables irq", int'(irq), 0);

    // R4: flag byte read does not clear
    wr(5'b11100, 0);                 // enable via write
    step;
    check("R8 write enables", int'(timerIrq), 1);
    rd(RD_FLAG);
    check("R4 flag read keeps", int'(timerFlag), 1);

    // R6: write clears and restarts
    wr(5'b10100, 5);
    check("R6 write clears", int'(timerFlag), 0);
    peek(RD_TIM, v);
    check("R6 counting", v, 6);

    // R9: write on the expiry edge
    wr(5'b10100, 2);                 // values 3,2,1
    step; step;
    peek(RD_TIM, v);
    check("R9 at last", v, 1);
    wr(5'b10100, 4);
    check("R9 no flag", int'(timerFlag), 0);
    peek(RD_TIM, v);
    check("R9 new load", v, 5);
    step;
    peek(RD_TIM, v);
    check("R9 still counting", v, 4);

    // R10: read on the expiry edge
    wr(5'b10100, 1);                 // values 2,1
    step;
    rd(RD_TIM);
    check("R10 flag set", int'(timerFlag), 1);
    peek(RD_TIM, v);
    check("R10 ff", v, 255);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++; nErr++;
      $display("FAIL R3 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

endmodule